// File: doc/BRIEF.md
# Store Queue with Load Disambiguation

This block keeps every outstanding store in program order between the moment it issues and the moment commit releases it to memory. A store takes the tail slot when it issues, together with the reorder-buffer tag of the instruction that will produce its data. Its address and its data are computed later, each on its own schedule, and are written into the slot by index in either order.

A load that wants to run early presents its address and the queue position it captured when it issued. Only the stores older than that position are considered. The block answers in the same cycle with one of four results. It stalls the load if any older store still has no address. It forwards the value of the youngest older store whose address matches. If that store's value is still missing, it returns the producer's tag. If no older store matches, it lets the load go to memory. Stores leave from the head, oldest first, and only once both their address and their data are known. A flush discards every entry.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready` is 1, `cmt_ready` is 0, `tail_pos` is 0, and every load gets the memory result.
- R2: A store presented on `alloc_valid` while fewer than DEPTH stores are held takes slot `tail_pos mod DEPTH` and advances `tail_pos` by one. When DEPTH stores are held, `alloc_ready` is 0 and an allocation attempt leaves `tail_pos` unchanged.
- R3: A slot's address and its data are written independently by slot index, in either order. A slot counts as address-known only once its address has been written.
- R4: `cmt_ready` is 1 only when the oldest store has both its address and its data. `cmt_addr` and `cmt_data` then show that store, and `cmt_pop` removes it. A pop while `cmt_ready` is 0 is ignored. Stores leave in allocation order.
- R5: The load result is stall (`ld_result` 2'b01) whenever any store older than the load position lacks its address.
- R6: If an older store's address equals the load address and that store's data is present, the result is forward-data (2'b10), with the value on `ld_data`.
- R7: If the matching older store's data is absent, the result is forward-tag (2'b11), with that store's producer tag on `ld_tag`.
- R8: Stores at or after the load position have no effect on the result. With no older match and no older unknown address, the result is memory (2'b00).
- R9: When several older stores match, the youngest of them supplies the result.
- R10: A flush empties the queue by the next cycle: `cmt_ready` goes to 0, `alloc_ready` to 1, and a load at the current `tail_pos` gets the memory result.
- R11: The number of held stores never exceeds DEPTH. An allocation and a pop in the same cycle leave the count unchanged while the tail still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all held stores |
| alloc_valid | input | 1 | Store issues this cycle |
| alloc_tag | input | TW | Producer tag of the issuing store's data |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IW | Slot the issuing store receives |
| tail_pos | output | PW | Position a load issuing now records (slot plus wrap bit) |
| addr_wr | input | 1 | Address write strobe |
| addr_wr_idx | input | IW | Slot receiving the address |
| addr_wr_value | input | AW | Store address |
| data_wr | input | 1 | Data write strobe |
| data_wr_idx | input | IW | Slot receiving the data |
| data_wr_value | input | DW | Store data |
| ld_addr | input | AW | Load address to check |
| ld_pos | input | PW | Position the load recorded at issue |
| ld_result | output | 2 | 00 memory, 01 stall, 10 forward data, 11 forward tag |
| ld_data | output | DW | Forwarded value |
| ld_tag | output | TW | Forwarded producer tag |
| cmt_pop | input | 1 | Release the oldest store to memory |
| cmt_ready | output | 1 | Oldest store is complete |
| cmt_addr | output | AW | Oldest store's address |
| cmt_data | output | DW | Oldest store's data |

## Verification
The assertions watch the occupancy rules on every cycle. The count stays within DEPTH, grows by one on an accepted allocation, shrinks by one on an accepted pop and is zero after a flush. A ready head store also keeps its address and data until it is popped. The load-result priorities cannot be shown that way, since they depend on the bench's choice of positions. These are the stall on an older unknown address, the blindness to younger stores, youngest-match selection and the switch from tag to value when data lands. Only directed scenarios show them, together with the order in which a scoreboard sees stores leave.

// File: rtl/sq_pkg.sv
package sq_pkg;
    typedef enum logic [1:0] {
        LD_MEM   = 2'b00,
        LD_STALL = 2'b01,
        LD_DATA  = 2'b10,
        LD_TAG   = 2'b11
    } ld_res_e;
endpackage

// File: rtl/sq_ptrs.sv
// Head and tail positions with one wrap bit; DEPTH must be a power of two.
module sq_ptrs #(
    parameter int DEPTH = 8,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    output logic [PW-1:0] head_pos,
    output logic [PW-1:0] tail_pos,
    output logic [PW-1:0] count,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d.head = ptr_q.tail;
        end else begin
            if (pop)  ptr_d.head = ptr_q.head + PW'(1);
            if (push) ptr_d.tail = ptr_q.tail + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign head_pos = ptr_q.head;
    assign tail_pos = ptr_q.tail;
    assign count    = ptr_q.tail - ptr_q.head;
    assign full     = (count == PW'(DEPTH));
    assign empty    = (count == '0);

    // R11
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= PW'(DEPTH));
endmodule

// File: rtl/sq_search.sv
// Associative scan over the stores older than a load position.
module sq_search
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 3,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  logic [PW-1:0] head_pos,
    input  logic [PW-1:0] ld_pos,
    input  logic [AW-1:0] ld_addr,
    input  logic          av   [DEPTH],
    input  logic          dv   [DEPTH],
    input  logic [AW-1:0] addr [DEPTH],
    input  logic [DW-1:0] data [DEPTH],
    input  logic [TW-1:0] tag  [DEPTH],
    output ld_res_e       result,
    output logic [DW-1:0] fwd_data,
    output logic [TW-1:0] fwd_tag
);
    logic [PW-1:0] older;
    logic [IW-1:0] slot;
    logic          stall, hit, hit_dv;

    always_comb begin
        older    = ld_pos - head_pos;
        stall    = 1'b0;
        hit      = 1'b0;
        hit_dv   = 1'b0;
        fwd_data = '0;
        fwd_tag  = '0;
        slot     = '0;
        // Walk from oldest to youngest so the last match wins.
        for (int k = 0; k < DEPTH; k++) begin
            slot = head_pos[IW-1:0] + IW'(k);
            if (PW'(k) < older) begin
                if (!av[slot]) begin
                    stall = 1'b1;
                end else if (addr[slot] == ld_addr) begin
                    hit      = 1'b1;
                    hit_dv   = dv[slot];
                    fwd_data = data[slot];
                    fwd_tag  = tag[slot];
                end
            end
        end
        if (stall)     result = LD_STALL;
        else if (!hit) result = LD_MEM;
        else if (hit_dv) result = LD_DATA;
        else           result = LD_TAG;
    end
endmodule

// File: rtl/store_queue.sv
module store_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int TW = 3,
    localparam int IW = $clog2(DEPTH),
    localparam int PW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          alloc_valid,
    input  logic [TW-1:0] alloc_tag,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    output logic [PW-1:0] tail_pos,
    input  logic          addr_wr,
    input  logic [IW-1:0] addr_wr_idx,
    input  logic [AW-1:0] addr_wr_value,
    input  logic          data_wr,
    input  logic [IW-1:0] data_wr_idx,
    input  logic [DW-1:0] data_wr_value,
    input  logic [AW-1:0] ld_addr,
    input  logic [PW-1:0] ld_pos,
    output logic [1:0]    ld_result,
    output logic [DW-1:0] ld_data,
    output logic [TW-1:0] ld_tag,
    input  logic          cmt_pop,
    output logic          cmt_ready,
    output logic [AW-1:0] cmt_addr,
    output logic [DW-1:0] cmt_data
);
    typedef struct packed {
        logic          av;
        logic          dv;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [TW-1:0] t;
    } ent_t;

    typedef struct packed {
        ent_t [DEPTH-1:0] ent;
    } sq_state_t;

    sq_state_t st_d, st_q;

    logic [PW-1:0] head_pos, count;
    logic          full, empty, alloc_fire, pop_fire;
    logic [IW-1:0] head_idx;

    assign head_idx    = head_pos[IW-1:0];
    assign alloc_ready = !full;
    assign alloc_idx   = tail_pos[IW-1:0];
    assign alloc_fire  = alloc_valid && !full && !flush;
    assign cmt_ready   = !empty && st_q.ent[head_idx].av && st_q.ent[head_idx].dv;
    assign pop_fire    = cmt_pop && cmt_ready && !flush;
    assign cmt_addr    = st_q.ent[head_idx].a;
    assign cmt_data    = st_q.ent[head_idx].d;

    sq_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (alloc_fire),
        .pop      (pop_fire),
        .flush    (flush),
        .head_pos (head_pos),
        .tail_pos (tail_pos),
        .count    (count),
        .full     (full),
        .empty    (empty)
    );

    // A write lands only in a slot that currently holds a store.
    function automatic logic slot_live(input logic [IW-1:0] idx,
                                       input logic [IW-1:0] hd,
                                       input logic [PW-1:0] cnt);
        logic [IW-1:0] off;
        off = idx - hd;
        return PW'(off) < cnt;
    endfunction

    always_comb begin
        st_d = st_q;
        if (alloc_fire) begin
            st_d.ent[alloc_idx].av = 1'b0;
            st_d.ent[alloc_idx].dv = 1'b0;
            st_d.ent[alloc_idx].a  = '0;
            st_d.ent[alloc_idx].d  = '0;
            st_d.ent[alloc_idx].t  = alloc_tag;
        end
        if (addr_wr && slot_live(addr_wr_idx, head_idx, count)) begin
            st_d.ent[addr_wr_idx].av = 1'b1;
            st_d.ent[addr_wr_idx].a  = addr_wr_value;
        end
        if (data_wr && slot_live(data_wr_idx, head_idx, count)) begin
            st_d.ent[data_wr_idx].dv = 1'b1;
            st_d.ent[data_wr_idx].d  = data_wr_value;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic          av_v [DEPTH];
    logic          dv_v [DEPTH];
    logic [AW-1:0] a_v  [DEPTH];
    logic [DW-1:0] d_v  [DEPTH];
    logic [TW-1:0] t_v  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign av_v[g] = st_q.ent[g].av;
        assign dv_v[g] = st_q.ent[g].dv;
        assign a_v[g]  = st_q.ent[g].a;
        assign d_v[g]  = st_q.ent[g].d;
        assign t_v[g]  = st_q.ent[g].t;
    end

    ld_res_e res;

    sq_search #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) i_search (
        .head_pos (head_pos),
        .ld_pos   (ld_pos),
        .ld_addr  (ld_addr),
        .av       (av_v),
        .dv       (dv_v),
        .addr     (a_v),
        .data     (d_v),
        .tag      (t_v),
        .result   (res),
        .fwd_data (ld_data),
        .fwd_tag  (ld_tag)
    );

    assign ld_result = res;

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!cmt_ready && alloc_ready && tail_pos == head_pos));

    // R4
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_ready && !cmt_pop && !flush) |=>
            (cmt_ready && $stable(cmt_addr) && $stable(cmt_data)));

    // R2
    alloc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid && alloc_ready && !flush && !(cmt_pop && cmt_ready)) |=>
            (tail_pos - head_pos) == $past(tail_pos - head_pos) + PW'(1));

    // R4
    pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_pop && cmt_ready && !alloc_valid && !flush) |=>
            (tail_pos - head_pos) == $past(tail_pos - head_pos) - PW'(1));

    // R11
    swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_pop && cmt_ready && alloc_valid && alloc_ready && !flush) |=>
            ((tail_pos - head_pos) == $past(tail_pos - head_pos) &&
             tail_pos == $past(tail_pos) + PW'(1)));
endmodule

// File: tb/test_store_queue.sv
module test_store_queue;
    localparam int AW = 32, DW = 32, TW = 3, IW = 3, PW = 4;

    logic          clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic          alloc_valid = 1'b0;
    logic [TW-1:0] alloc_tag = '0;
    logic          alloc_ready;
    logic [IW-1:0] alloc_idx;
    logic [PW-1:0] tail_pos;
    logic          addr_wr = 1'b0, data_wr = 1'b0;
    logic [IW-1:0] addr_wr_idx = '0, data_wr_idx = '0;
    logic [AW-1:0] addr_wr_value = '0;
    logic [DW-1:0] data_wr_value = '0;
    logic [AW-1:0] ld_addr = '0;
    logic [PW-1:0] ld_pos = '0;
    logic [1:0]    ld_result;
    logic [DW-1:0] ld_data;
    logic [TW-1:0] ld_tag;
    logic          cmt_pop = 1'b0, cmt_ready;
    logic [AW-1:0] cmt_addr;
    logic [DW-1:0] cmt_data;

    int checks = 0, errors = 0;
    logic [AW+DW-1:0] exp_q [$];

    store_queue i_store_queue (.*);

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic eq(input string req, input logic [63:0] act, input logic [63:0] exp);
        chk(act === exp, req, act, exp);
    endtask

    task automatic do_alloc(input logic [TW-1:0] t);
        @(negedge clk); alloc_valid = 1'b1; alloc_tag = t;
        @(negedge clk); alloc_valid = 1'b0;
    endtask

    task automatic do_addr(input logic [IW-1:0] i, input logic [AW-1:0] a);
        @(negedge clk); addr_wr = 1'b1; addr_wr_idx = i; addr_wr_value = a;
        @(negedge clk); addr_wr = 1'b0;
    endtask

    task automatic do_data(input logic [IW-1:0] i, input logic [DW-1:0] d);
        @(negedge clk); data_wr = 1'b1; data_wr_idx = i; data_wr_value = d;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic do_load(input string req, input logic [PW-1:0] p, input logic [AW-1:0] a,
                           input logic [1:0] er, input logic [DW-1:0] ev);
        ld_pos = p; ld_addr = a; #1;
        eq(req, {30'd0, ld_result}, {30'd0, er});
        if (er == 2'b10) eq(req, {32'd0, ld_data}, {32'd0, ev});
        if (er == 2'b11) eq(req, {61'd0, ld_tag}, {32'd0, ev});
    endtask

    // Driver: expected retirement goes into the scoreboard queue.
    task automatic do_commit(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back({a, d});
        @(negedge clk); cmt_pop = 1'b1;
        @(negedge clk); cmt_pop = 1'b0;
    endtask

    // Monitor: every accepted pop is compared with the oldest expectation.
    always @(posedge clk) begin
        if (rst_n && cmt_pop && cmt_ready && !flush) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected retire", {cmt_addr, cmt_data}, 64'd0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                eq("R4 retire order", {cmt_addr, cmt_data}, e);
            end
        end
    end

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        eq("R1 alloc_ready", {63'd0, alloc_ready}, 64'd1);
        eq("R1 cmt_ready", {63'd0, cmt_ready}, 64'd0);
        eq("R1 tail_pos", {60'd0, tail_pos}, 64'd0);
        do_load("R1 empty load", 4'd0, 32'h100, 2'b00, 0);

        // R2 two stores: A slot0 tag5, B slot1 tag6
        eq("R2 alloc_idx", {61'd0, alloc_idx}, 64'd0);
        do_alloc(3'd5);
        do_alloc(3'd6);
        eq("R2 tail after two", {60'd0, tail_pos}, 64'd2);
        do_load("R5 unknown older addr", 4'd2, 32'h100, 2'b01, 0);
        do_load("R8 younger unknown ignored", 4'd0, 32'h100, 2'b00, 0);

        do_addr(3'd1, 32'h100);
        do_load("R5 one older still unknown", 4'd2, 32'h100, 2'b01, 0);
        do_addr(3'd0, 32'h200);
        do_load("R7 tag forward", 4'd2, 32'h100, 2'b11, 6);
        do_data(3'd1, 32'hBBBB);
        do_load("R6 data forward", 4'd2, 32'h100, 2'b10, 32'hBBBB);
        do_load("R8 no match", 4'd2, 32'h300, 2'b00, 0);
        do_load("R8 younger match ignored", 4'd1, 32'h100, 2'b00, 0);

        // R9 third store C slot2 tag7 to the same address
        do_alloc(3'd7);
        do_addr(3'd2, 32'h100);
        do_load("R9 youngest tag", 4'd3, 32'h100, 2'b11, 7);
        do_data(3'd2, 32'hCCCC);
        do_load("R9 youngest data", 4'd3, 32'h100, 2'b10, 32'hCCCC);
        do_load("R8 older view only", 4'd2, 32'h100, 2'b10, 32'hBBBB);

        // R4 head A lacks data: not ready, pop ignored
        eq("R4 head not ready", {63'd0, cmt_ready}, 64'd0);
        @(negedge clk); cmt_pop = 1'b1;
        @(negedge clk); cmt_pop = 1'b0;
        do_data(3'd0, 32'hAAAA);
        eq("R4 head ready", {63'd0, cmt_ready}, 64'd1);
        eq("R4 head addr kept", {32'd0, cmt_addr}, 64'h200);
        do_commit(32'h200, 32'hAAAA);
        do_load("R8 retired store gone", 4'd2, 32'h200, 2'b00, 0);
        do_commit(32'h100, 32'hBBBB);
        do_commit(32'h100, 32'hCCCC);
        eq("R4 drained", {63'd0, cmt_ready}, 64'd0);

        // R3 data before address; fill from position 3
        for (int k = 0; k < 7; k++) do_alloc(3'(k));
        eq("R2 tail after fill", {60'd0, tail_pos}, 64'd10);
        do_data(3'd3, 32'h1111);
        do_load("R3 data first still unknown", 4'd4, 32'h40, 2'b01, 0);
        do_addr(3'd3, 32'h40);
        do_load("R3 data first then addr", 4'd4, 32'h40, 2'b10, 32'h1111);
        do_load("R5 later older unknown", 4'd10, 32'h40, 2'b01, 0);

        // R11 pop and allocate together
        exp_q.push_back({32'h40, 32'h1111});
        @(negedge clk); cmt_pop = 1'b1; alloc_valid = 1'b1; alloc_tag = 3'd2;
        @(negedge clk); cmt_pop = 1'b0; alloc_valid = 1'b0;
        eq("R11 tail advanced", {60'd0, tail_pos}, 64'd11);
        eq("R11 still room", {63'd0, alloc_ready}, 64'd1);

        do_alloc(3'd3);
        eq("R2 full", {63'd0, alloc_ready}, 64'd0);
        do_alloc(3'd4);
        eq("R2 full alloc ignored", {60'd0, tail_pos}, 64'd12);

        // R10 flush
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        eq("R10 cmt_ready", {63'd0, cmt_ready}, 64'd0);
        eq("R10 alloc_ready", {63'd0, alloc_ready}, 64'd1);
        do_load("R10 load after flush", 4'd12, 32'h40, 2'b00, 0);

        do_alloc(3'd1);
        do_addr(3'd4, 32'h80);
        do_data(3'd4, 32'h99);
        do_commit(32'h80, 32'h99);
        @(negedge clk);
        eq("R4 all expected retired", exp_q.size(), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule